// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synchronous word-wide memory with a flow-through read path and a write pipeline built so that a read and a write can occupy back-to-back clocks in either order, with no idle cycle on the data bus. Command, address and chip-select inputs are captured on the rising clock edge. A read returns data in the same clock period as its captured address, with no output register. A write takes its data word and byte-lane selects one clock after its command and commits them to the array on that edge.

A two-bit burst counter lets a master issue one address and then advance through a four-word group in linear (wrapping) or interleaved (XOR) order. An active-low clock enable freezes every register, including a pending write. The data bus is modelled as separate in, out and drive-enable ports. Drive is withheld automatically during write data phases and deselected cycles, and an asynchronous output-enable can also withhold it. The array depth follows an address-width parameter: a width of 16 gives 65,536 words of 32 bits. The default is smaller, to keep elaboration light.

Top module: `sramZbtFlow`

## Requirements
- R1: While reset is asserted and in the first cycle after it, dataOutEn is 0.
- R2: A load cycle (advLoad=0) with ce1N=0, ce2=1, ce3N=0 and wrEnN=1 starts a read. In the clock period that follows that edge, dataOut equals the stored word at addr and dataOutEn is 1 when oeN is 0.
- R3: Reads and writes may alternate on every clock with no idle cycle. A read captured on the edge that commits a write to the same address returns the newly written word.
- R4: A load cycle with wrEnN=0 and all chips selected starts a write. dataIn and byteEnN are sampled on the next enabled edge. byteEnN[i]=0 writes bits 8i+7:8i, and byteEnN[i]=1 leaves that lane unchanged.
- R5: A load cycle with ce1N=1, ce2=0 or ce3N=1 is a deselect. No data is driven in the following period and no write commits on the next edge.
- R6: In the period after a write command is captured (the write data phase), dataOutEn is 0.
- R7: oeN=1 forces dataOutEn to 0 at once, without waiting for a clock edge.
- R8: An edge with clkEnN=1 has no effect. dataOut and dataOutEn hold, no write commits, and a pending write or burst resumes unchanged on the next enabled edge.
- R9: advLoad=1 continues the current burst. With burstInterleave=0, the n-th advance accesses low address bits (start+n) mod 4, and the upper bits stay fixed.
- R10: With burstInterleave=1, the n-th advance accesses low address bits start XOR (n mod 4).
- R11: advLoad=1 after a deselect keeps the block deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| clkEnN | input | 1 | Active-low clock enable; high freezes the block |
| addr | input | addrW | Word address, captured on load cycles |
| advLoad | input | 1 | 1 advances the current burst, 0 loads a new command |
| wrEnN | input | 1 | Active-low write command, captured on load cycles |
| byteEnN | input | dataW/8 | Active-low byte-lane selects, taken in the write data phase |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3N | input | 1 | Chip select, active low |
| burstInterleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oeN | input | 1 | Asynchronous active-low output enable |
| dataIn | input | dataW | Write data (bus input side) |
| dataOut | output | dataW | Flow-through read data |
| dataOutEn | output | 1 | Bus drive enable for dataOut |

## Verification
The bench drives isolated reads and writes, strict read/write alternation on the same address, and partial byte masks. These separate an array that commits on the right edge from one that commits early, late or with the wrong lanes. Each chip select is dropped alone to show that every one of them gates the command. Stalls placed inside a pending write and inside a burst show whether the clock enable really freezes state rather than only the outputs. Bursts from an unaligned start, run past four beats in both orders, tell linear wrap from XOR sequencing.

// File: rtl/sramZbtPkg.sv
package sramZbtPkg;
  typedef struct packed {
    logic readDrive;    // captured op is a valid read
    logic writeCommit;  // captured op is a valid write awaiting data
  } ctrlStrobeT;
endpackage

// File: rtl/sramZbtCtrl.sv
module sramZbtCtrl
  import sramZbtPkg::*;
#(
  parameter int addrW  = 10,
  parameter int burstW = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic [addrW-1:0] addr,
  input  logic             advLoad,
  input  logic             wrEnN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             burstInterleave,
  output ctrlStrobeT       strobes,
  output logic [addrW-1:0] effAddr
);
  logic              opValid;
  logic              opWrite;
  logic [addrW-1:0]  baseAddr;
  logic [burstW-1:0] burstCnt;
  logic [burstW-1:0] lowBits;
  logic              chipSel;

  assign chipSel = !ce1N && ce2 && !ce3N;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opValid  <= 1'b0;
      opWrite  <= 1'b0;
      baseAddr <= '0;
      burstCnt <= '0;
    end else if (clkEn) begin
      if (!advLoad) begin
        opValid  <= chipSel;
        opWrite  <= !wrEnN;
        baseAddr <= addr;
        burstCnt <= '0;
      end else if (opValid) begin
        burstCnt <= burstCnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (burstInterleave) lowBits = baseAddr[burstW-1:0] ^ burstCnt;
    else                 lowBits = baseAddr[burstW-1:0] + burstCnt;
  end

  assign effAddr             = {baseAddr[addrW-1:burstW], lowBits};
  assign strobes.readDrive   = opValid && !opWrite;
  assign strobes.writeCommit = opValid && opWrite;
endmodule

// File: rtl/sramZbtData.sv
module sramZbtData
  import sramZbtPkg::*;
#(
  parameter int addrW = 10,
  parameter int dataW = 32,
  parameter int laneW = 8
) (
  input  logic                   clk,
  input  logic                   clkEn,
  input  ctrlStrobeT             strobes,
  input  logic [addrW-1:0]       effAddr,
  input  logic [dataW/laneW-1:0] byteEnN,
  input  logic [dataW-1:0]       dataIn,
  input  logic                   oeN,
  output logic [dataW-1:0]       dataOut,
  output logic                   dataOutEn
);
  localparam int depth = 1 << addrW;
  localparam int lanes = dataW / laneW;

  logic [dataW-1:0] memArray [depth];

  always_ff @(posedge clk) begin
    if (clkEn && strobes.writeCommit) begin
      for (int i = 0; i < lanes; i++) begin
        if (!byteEnN[i]) memArray[effAddr][i*laneW +: laneW] <= dataIn[i*laneW +: laneW];
      end
    end
  end

  assign dataOut   = memArray[effAddr];
  assign dataOutEn = strobes.readDrive && !oeN;
endmodule

// File: rtl/sramZbtFlow.sv
module sramZbtFlow
  import sramZbtPkg::*;
#(
  parameter int addrW = 10,
  parameter int dataW = 32,
  parameter int laneW = 8,
  localparam int lanes = dataW / laneW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnN,
  input  logic [addrW-1:0] addr,
  input  logic             advLoad,
  input  logic             wrEnN,
  input  logic [lanes-1:0] byteEnN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             burstInterleave,
  input  logic             oeN,
  input  logic [dataW-1:0] dataIn,
  output logic [dataW-1:0] dataOut,
  output logic             dataOutEn
);
  ctrlStrobeT       strobes;
  logic [addrW-1:0] effAddr;

  sramZbtCtrl #(.addrW(addrW), .burstW(2)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(!clkEnN), .addr(addr), .advLoad(advLoad),
    .wrEnN(wrEnN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .burstInterleave(burstInterleave), .strobes(strobes), .effAddr(effAddr)
  );

  sramZbtData #(.addrW(addrW), .dataW(dataW), .laneW(laneW)) uData (
    .clk(clk), .clkEn(!clkEnN), .strobes(strobes), .effAddr(effAddr),
    .byteEnN(byteEnN), .dataIn(dataIn), .oeN(oeN),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/sramZbtFlowChk.sv
module sramZbtFlowChk #(
  parameter int addrW = 10,
  parameter int dataW = 32,
  parameter int lanes = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEnN,
  input logic             advLoad,
  input logic             wrEnN,
  input logic             ce1N,
  input logic             ce2,
  input logic             ce3N,
  input logic             oeN,
  input logic [dataW-1:0] dataOut,
  input logic             dataOutEn
);
  logic selLoad;
  assign selLoad = !clkEnN && !advLoad && !ce1N && ce2 && !ce3N;

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    (selLoad && wrEnN) |=> (dataOutEn || oeN));

  assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLoad && (ce1N || !ce2 || ce3N)) |=> !dataOutEn);

  assert_write_phase_hiz_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selLoad && !wrEnN) |=> !dataOutEn);

  assert_oe_gates_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> !oeN);

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(dataOut));
endmodule

bind sramZbtFlow sramZbtFlowChk #(.addrW(addrW), .dataW(dataW), .lanes(lanes)) uChk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLoad(advLoad), .wrEnN(wrEnN),
  .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .oeN(oeN),
  .dataOut(dataOut), .dataOutEn(dataOutEn)
);

// File: tb/tb_sramZbtFlow.sv
module tb_sramZbtFlow;
  localparam int addrW = 10;
  localparam int dataW = 32;

  logic clk = 0, rstN = 0, clkEnN = 0, advLoad = 0, wrEnN = 1;
  logic [3:0] byteEnN = 4'hF;
  logic ce1N = 0, ce2 = 1, ce3N = 0, burstInterleave = 0, oeN = 0;
  logic [addrW-1:0] addr = '0;
  logic [dataW-1:0] dataIn = '0;
  logic [dataW-1:0] dataOut;
  logic dataOutEn;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] refMem [int];
  bit refValid = 0, refWrite = 0;
  int refBase = 0, refCnt = 0;

  always #4 clk = ~clk;

  sramZbtFlow #(.addrW(addrW), .dataW(dataW)) dut (.*);

  function automatic int refAddr();
    int low;
    low = burstInterleave ? ((refBase & 3) ^ refCnt) : (((refBase & 3) + refCnt) % 4);
    return (refBase & ~3) | low;
  endfunction

  task automatic check(input string tag);
    bit expEn;
    expEn = refValid && !refWrite && !oeN;
    compared++;
    if (dataOutEn !== expEn) begin
      mismatched++;
      $display("FAIL %s dataOutEn actual=%0b expected=%0b", tag, dataOutEn, expEn);
    end
    if (expEn && refMem.exists(refAddr())) begin
      compared++;
      if (dataOut !== refMem[refAddr()]) begin
        mismatched++;
        $display("FAIL %s dataOut actual=%h expected=%h", tag, dataOut, refMem[refAddr()]);
      end
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (rstN && !clkEnN) begin
      if (refValid && refWrite) begin
        logic [31:0] w;
        w = refMem.exists(refAddr()) ? refMem[refAddr()] : 32'h0;
        for (int i = 0; i < 4; i++) if (!byteEnN[i]) w[i*8 +: 8] = dataIn[i*8 +: 8];
        refMem[refAddr()] = w;
      end
      if (!advLoad) begin
        refValid = !ce1N && ce2 && !ce3N;
        refWrite = !wrEnN;
        refBase  = int'(addr);
        refCnt   = 0;
      end else if (refValid) begin
        refCnt = (refCnt + 1) % 4;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic cmdLoad(input int a, input bit wr);
    advLoad = 0; ce1N = 0; ce2 = 1; ce3N = 0; addr = a[addrW-1:0]; wrEnN = !wr;
  endtask
  task automatic cmdAdv();
    advLoad = 1;
  endtask
  task automatic cmdDesel(input int which);
    advLoad = 0; ce1N = (which == 1); ce2 = !(which == 2); ce3N = (which == 3);
  endtask
  task automatic setData(input logic [31:0] d, input logic [3:0] be);
    dataIn = d; byteEnN = be;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    cmdDesel(1);
    repeat (2) @(negedge clk);
    check("R1 in reset");
    rstN = 1;
    tick("R1 after reset");

    // R4 full writes, alternating data phase with next command
    cmdLoad(8, 1);                                  tick("R6 write cmd");
    setData(32'hA1B2C3D4, 4'h0); cmdLoad(9, 1);     tick("R6 write after write");
    setData(32'h11223344, 4'h0); cmdLoad(8, 0);     tick("R3 read after write");
    setData(32'h0, 4'hF);        cmdLoad(9, 0);     tick("R2 read");
    // R3 strict alternation on the same address
    cmdLoad(20, 1);                                 tick("R3 w");
    setData(32'hDEADBEEF, 4'h0); cmdLoad(20, 0);    tick("R3 r new data");
    cmdLoad(20, 1);                                 tick("R3 w2");
    setData(32'h55AA55AA, 4'h0); cmdLoad(20, 0);    tick("R3 r2");
    // R4 partial lanes
    cmdLoad(20, 1);                                 tick("R4 cmd");
    setData(32'h00FF0000, 4'b1011); cmdLoad(20, 0); tick("R4 lane2 only");
    cmdLoad(20, 1);                                 tick("R4 cmd2");
    setData(32'h12000034, 4'b0110); cmdLoad(20, 0); tick("R4 lanes 0 and 3");
    // R5 each chip select drops a write; readback unchanged
    for (int k = 1; k <= 3; k++) begin
      cmdDesel(k); wrEnN = 0;                       tick("R5 deselect");
      setData(32'hFFFFFFFF, 4'h0); cmdLoad(20, 0);  tick("R5 no commit");
    end
    // R7 async output enable
    oeN = 1; #1; check("R7 oeN high");
    cmdLoad(9, 0); tick("R7 read with oeN high");
    oeN = 0; #1; check("R7 oeN low");
    // R8 stall inside a pending write
    cmdLoad(30, 1);                                 tick("R8 write cmd");
    clkEnN = 1; setData(32'hBADBAD00, 4'h0); cmdLoad(8, 1);
    tick("R8 stall 1"); tick("R8 stall 2");
    clkEnN = 0; setData(32'hCAFEF00D, 4'h0); cmdLoad(30, 0); tick("R8 resumed commit");
    cmdLoad(8, 0);                                  tick("R8 addr 8 untouched");
    clkEnN = 1; cmdLoad(30, 0);                     tick("R8 read held");
    clkEnN = 0;
    // fill a 4-word group 40..43 with a linear write burst
    cmdLoad(40, 1);                                 tick("R9 wburst");
    for (int n = 0; n < 4; n++) begin
      setData(32'h40400000 + n, 4'h0);
      if (n < 3) cmdAdv(); else cmdLoad(42, 0);
      tick("R9 wburst beat");
    end
    // linear read burst from 42 past the wrap, with a stall
    for (int n = 0; n < 5; n++) begin
      cmdAdv(); if (n == 2) clkEnN = 1;
      tick("R9 linear advance");
      clkEnN = 0;
    end
    // R10 interleaved read from 41
    burstInterleave = 1;
    cmdLoad(41, 0);                                 tick("R10 load");
    for (int n = 0; n < 5; n++) begin cmdAdv(); tick("R10 interleave advance"); end
    burstInterleave = 0;
    // R11 advance after deselect
    cmdDesel(2);                                    tick("R11 deselect");
    cmdAdv(); tick("R11 adv stays off"); tick("R11 adv stays off 2");
    cmdLoad(43, 0);                                 tick("R2 final read");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule